// File: doc/BRIEF.md
# Section Parity Error Monitor

This block watches the byte stream of a received 155 Mb/s synchronous optical frame after framing. Every accepted byte is folded into an 8-bit interleaved parity. When a frame ends, that parity is held. The first byte of the following frame is the section parity byte, and it is compared against the held value. Mismatches feed a saturating error counter. The line remote-error field, carried in a fixed overhead byte of the last row, feeds a second counter.

Each counter has its own mode. In bit mode it adds the number of errored bits. In frame mode it adds one for each frame that shows any error. A small register port gives software the following:

- a control byte with the counting modes,
- an interrupt status byte that clears when read,
- the two counters, which also clear when read.

An active-low interrupt pin is held low while any status bit is set.

The frame geometry (rows, columns) and the column of the remote-error byte are parameters, so a bench can run a miniature frame.

Top module: `sect_bip_mon`

## Requirements
- R1: Parity is the XOR of every accepted byte of one complete frame, the parity byte included. It is compared with the byte at position 0 (row 1, column 1) of the next frame. With control bit 0 = 0, the parity counter (address 2) grows by the number of differing bits (0..8).
- R2: With control bit 0 = 1, the parity counter grows by exactly 1 for each compared frame whose parity byte differs in any bit.
- R3: No comparison is made for the first frame after reset. None is made after the loss-of-frame input was high. None is made after a frame-start marker arrived before the previous frame had completed.
- R4: The remote-error value is the whole byte at the last row, column M1_COL (0-based). Values above REI_MAX count as zero. With control bit 2 = 0, the remote-error counter (address 3) grows by that value.
- R5: With control bit 2 = 1, the remote-error counter grows by exactly 1 for each frame whose remote-error value is nonzero.
- R6: Interrupt status (address 1) bit 3 is set on any parity mismatch. Bit 5 is set on a nonzero remote-error value. The other status bits read 0. `irq_n` is low while any status bit is set, from the clock edge after the event.
- R7: A read of the status register returns its contents and clears it. `irq_n` then returns high.
- R8: Both counters saturate at all ones.
- R9: A read of either counter returns its value and clears it.
- R10: The control register is at address 0. Bits 6:0 are read/write and bit 7 reads 0. All registers reset to 0. Read data is valid in the cycle after `reg_rd`.
- R11: Cycles with `byte_en` low are ignored. They neither advance the byte position nor change the parity.
- R12: After reset, all counters and status read 0 and `irq_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| byte_en | input | 1 | Byte on `din` is valid this cycle |
| sof | input | 1 | Marks the first byte of a frame |
| lof | input | 1 | Loss of frame; drops alignment and parity history |
| din | input | 8 | Received byte |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | CNT_W | Registered read data |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A corrupted held parity or a wrong byte position shows up at the counter port within one frame. The next parity byte then reports a bit count other than the popcount of the injected error mask. A stale history flag shows as a count on the first frame after reset, loss of frame or a restart.

A wrong saturation or clear path shows on the first counter read after the event. A stuck status bit keeps `irq_n` low right after the status read.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

   typedef enum logic [1:0] {
      REG_CTRL   = 2'd0,
      REG_STAT   = 2'd1,
      REG_B1CNT  = 2'd2,
      REG_REICNT = 2'd3
   } sbm_reg_e;

   localparam int STAT_PAR_BIT  = 3;
   localparam int STAT_REI_BIT  = 5;
   localparam int CTL_PAR_MODE  = 0;
   localparam int CTL_REI_MODE  = 2;
   localparam logic [7:0] CTL_RW_MASK = 8'h7F;

   function automatic logic [7:0] popcnt8(input logic [7:0] v);
      logic [7:0] n;
      n = '0;
      for (int i = 0; i < 8; i++) n = n + {7'd0, v[i]};
      return n;
   endfunction

endpackage

// File: rtl/sbm_pos_track.sv
module sbm_pos_track #(
   parameter int FRAME_BYTES = 2430,
   parameter int M1_POS      = 2168,
   parameter int POS_W       = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             byte_en,
   input  logic             sof,
   input  logic             lof,
   output logic [POS_W-1:0] pos_reg,
   output logic             acc_en,
   output logic             is_first,
   output logic             is_last,
   output logic             is_m1,
   output logic             restart
);

   logic             synced_q;
   logic [POS_W-1:0] pos_q;
   logic [POS_W-1:0] idx;

   assign acc_en   = byte_en && !lof && (sof || synced_q);
   assign idx      = sof ? '0 : pos_q;
   assign is_first = acc_en && (idx == '0);
   assign is_last  = acc_en && (idx == POS_W'(FRAME_BYTES - 1));
   assign is_m1    = acc_en && (idx == POS_W'(M1_POS));
   assign restart  = acc_en && sof && synced_q && (pos_q != '0);
   assign pos_reg  = pos_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         synced_q <= 1'b0;
         pos_q    <= '0;
      end else if (lof) begin
         synced_q <= 1'b0;
         pos_q    <= '0;
      end else if (acc_en) begin
         synced_q <= 1'b1;
         pos_q    <= is_last ? '0 : idx + POS_W'(1);
      end
   end

endmodule

// File: rtl/sbm_parity.sv
module sbm_parity (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       lof,
   input  logic       en,
   input  logic       first,
   input  logic       last,
   input  logic       restart,
   input  logic [7:0] din,
   output logic       cmp_en,
   output logic [7:0] mis_mask,
   output logic       prev_ok
);

   logic [7:0] acc_q;
   logic [7:0] prev_q;
   logic       prev_ok_q;
   logic [7:0] run_par;

   assign run_par  = (first ? 8'h00 : acc_q) ^ din;
   assign cmp_en   = en && first && prev_ok_q && !restart;
   assign mis_mask = prev_q ^ din;
   assign prev_ok  = prev_ok_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q     <= '0;
         prev_q    <= '0;
         prev_ok_q <= 1'b0;
      end else if (lof) begin
         prev_ok_q <= 1'b0;
      end else if (en) begin
         acc_q <= run_par;
         if (last) begin
            prev_q    <= run_par;
            prev_ok_q <= 1'b1;
         end else if (restart) begin
            prev_ok_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/sbm_err_cnt.sv
module sbm_err_cnt #(
   parameter int W        = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ev,
   input  logic [7:0]   amount,
   input  logic         per_frame,
   input  logic         clr,
   output logic [W-1:0] cnt
);

   localparam int SW = W + 1;

   logic [7:0]   inc_amt;
   logic [W-1:0] base;
   logic [W:0]   sum;
   logic [W-1:0] nxt;
   logic [W-1:0] cnt_q;

   assign inc_amt = !ev ? 8'd0 : (per_frame ? {7'd0, amount != 8'd0} : amount);
   assign base    = clr ? '0 : cnt_q;
   assign sum     = {1'b0, base} + SW'(inc_amt);

   generate
      if (SATURATE) begin : g_sat
         assign nxt = sum[W] ? '1 : sum[W-1:0];
      end else begin : g_wrap
         assign nxt = sum[W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else if (ev || clr) cnt_q <= nxt;
   end

   assign cnt = cnt_q;

endmodule

// File: rtl/sect_bip_mon.sv
module sect_bip_mon #(
   parameter int ROWS    = 9,
   parameter int COLS    = 270,
   parameter int M1_COL  = 8,
   parameter int CNT_W   = 16,
   parameter int REI_MAX = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             byte_en,
   input  logic             sof,
   input  logic             lof,
   input  logic [7:0]       din,
   input  logic             reg_wr,
   input  logic             reg_rd,
   input  logic [1:0]       reg_addr,
   input  logic [7:0]       reg_wdata,
   output logic [CNT_W-1:0] reg_rdata,
   output logic             irq_n
);
   import sbm_pkg::*;

   localparam int FRAME_BYTES = ROWS * COLS;
   localparam int POS_W       = $clog2(FRAME_BYTES);
   localparam int M1_POS      = (ROWS - 1) * COLS + M1_COL;

   generate
      if (FRAME_BYTES < 2) begin : g_bad_frame
         $error("frame must hold at least two bytes");
      end
      if (M1_COL < 1 || M1_COL >= COLS) begin : g_bad_m1
         $error("M1_COL must lie in the last row, after column 0");
      end
      if (CNT_W < 8) begin : g_bad_cnt
         $error("CNT_W must be at least 8");
      end
      if (REI_MAX < 1 || REI_MAX > 255) begin : g_bad_rei
         $error("REI_MAX must be 1..255");
      end
   endgenerate

   logic [POS_W-1:0] pos_reg;
   logic             acc_en, is_first, is_last, is_m1, restart;
   logic             cmp_en, prev_ok;
   logic [7:0]       mis_mask;
   logic [7:0]       ctrl_q;
   logic [7:0]       stat_q;
   logic [7:0]       stat_set;
   logic [7:0]       rei_val;
   logic             b1_err, rei_err;
   logic             rd_stat, rd_b1, rd_rei;
   logic [CNT_W-1:0] b1_cnt, rei_cnt;
   logic [CNT_W-1:0] rdata_q;

   sbm_pos_track #(
      .FRAME_BYTES(FRAME_BYTES), .M1_POS(M1_POS), .POS_W(POS_W)
   ) u_pos (
      .clk(clk), .rst_n(rst_n), .byte_en(byte_en), .sof(sof), .lof(lof),
      .pos_reg(pos_reg), .acc_en(acc_en), .is_first(is_first),
      .is_last(is_last), .is_m1(is_m1), .restart(restart)
   );

   sbm_parity u_par (
      .clk(clk), .rst_n(rst_n), .lof(lof), .en(acc_en), .first(is_first),
      .last(is_last), .restart(restart), .din(din), .cmp_en(cmp_en),
      .mis_mask(mis_mask), .prev_ok(prev_ok)
   );

   assign rei_val = (din <= 8'(REI_MAX)) ? din : 8'd0;
   assign b1_err  = cmp_en && (mis_mask != 8'd0);
   assign rei_err = is_m1 && (rei_val != 8'd0);

   assign rd_stat = reg_rd && (sbm_reg_e'(reg_addr) == REG_STAT);
   assign rd_b1   = reg_rd && (sbm_reg_e'(reg_addr) == REG_B1CNT);
   assign rd_rei  = reg_rd && (sbm_reg_e'(reg_addr) == REG_REICNT);

   sbm_err_cnt #(.W(CNT_W), .SATURATE(1'b1)) u_b1_cnt (
      .clk(clk), .rst_n(rst_n), .ev(cmp_en), .amount(popcnt8(mis_mask)),
      .per_frame(ctrl_q[CTL_PAR_MODE]), .clr(rd_b1), .cnt(b1_cnt)
   );

   sbm_err_cnt #(.W(CNT_W), .SATURATE(1'b1)) u_rei_cnt (
      .clk(clk), .rst_n(rst_n), .ev(is_m1), .amount(rei_val),
      .per_frame(ctrl_q[CTL_REI_MODE]), .clr(rd_rei), .cnt(rei_cnt)
   );

   always_comb begin
      stat_set = 8'd0;
      stat_set[STAT_PAR_BIT] = b1_err;
      stat_set[STAT_REI_BIT] = rei_err;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         stat_q  <= '0;
         rdata_q <= '0;
      end else begin
         if (reg_wr && sbm_reg_e'(reg_addr) == REG_CTRL)
            ctrl_q <= reg_wdata & CTL_RW_MASK;
         stat_q <= (rd_stat ? 8'd0 : stat_q) | stat_set;
         if (reg_rd) begin
            unique case (sbm_reg_e'(reg_addr))
               REG_CTRL:   rdata_q <= CNT_W'(ctrl_q);
               REG_STAT:   rdata_q <= CNT_W'(stat_q);
               REG_B1CNT:  rdata_q <= b1_cnt;
               REG_REICNT: rdata_q <= rei_cnt;
               default:    rdata_q <= '0;
            endcase
         end
      end
   end

   assign reg_rdata = rdata_q;
   assign irq_n     = (stat_q == 8'd0);

endmodule

// File: rtl/sbm_chk.sv
module sbm_chk #(
   parameter int CNT_W = 16,
   parameter int POS_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             byte_en,
   input logic             lof,
   input logic             reg_rd,
   input logic [1:0]       reg_addr,
   input logic [CNT_W-1:0] reg_rdata,
   input logic             irq_n,
   input logic [CNT_W-1:0] b1_cnt,
   input logic             b1_err,
   input logic             prev_ok,
   input logic [POS_W-1:0] pos_reg
);

   // R9
   rd_b1_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == 2'd2) |=> (reg_rdata == $past(b1_cnt)));

   // R8
   sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (b1_cnt == {CNT_W{1'b1}} && !(reg_rd && reg_addr == 2'd2))
      |=> (b1_cnt == {CNT_W{1'b1}}));

   // R3
   no_hist_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !prev_ok |-> !b1_err);

   // R6
   irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      b1_err |=> !irq_n);

   // R11
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!byte_en && !lof) |=> $stable(pos_reg));

   // R10
   ctl_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == 2'd0) |=> (reg_rdata[7] == 1'b0));

endmodule

bind sect_bip_mon sbm_chk #(.CNT_W(CNT_W), .POS_W(POS_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .byte_en(byte_en), .lof(lof),
   .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
   .irq_n(irq_n), .b1_cnt(b1_cnt), .b1_err(b1_err), .prev_ok(prev_ok),
   .pos_reg(pos_reg)
);

// File: tb/sim_sect_bip_mon.sv
module sim_sect_bip_mon;
   localparam int CLK_PERIOD = 10;
   localparam int ROWS = 3, COLS = 4, M1_COL = 2, CNT_W = 8, REI_MAX = 24;
   localparam int NB = ROWS * COLS;
   localparam int M1P = (ROWS - 1) * COLS + M1_COL;

   logic clk = 1'b0, rst_n = 1'b0;
   logic byte_en = 1'b0, sof = 1'b0, lof = 1'b0;
   logic [7:0] din = '0;
   logic reg_wr = 1'b0, reg_rd = 1'b0;
   logic [1:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [CNT_W-1:0] reg_rdata;
   logic irq_n;

   int checks = 0, errors = 0;
   logic [7:0] prev_par = '0;
   bit have_prev = 1'b0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sect_bip_mon #(.ROWS(ROWS), .COLS(COLS), .M1_COL(M1_COL),
                  .CNT_W(CNT_W), .REI_MAX(REI_MAX)) u0 (
      .clk(clk), .rst_n(rst_n), .byte_en(byte_en), .sof(sof), .lof(lof),
      .din(din), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n));

   function automatic int popc(input logic [7:0] v);
      int n = 0;
      for (int i = 0; i < 8; i++) n += v[i];
      return n;
   endfunction

   function automatic int rei_ok(input int v);
      return (v <= REI_MAX) ? v : 0;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic reg_read(input logic [1:0] a, output int v);
      @(negedge clk); reg_rd = 1'b1; reg_addr = a;
      @(negedge clk); reg_rd = 1'b0; v = int'(reg_rdata);
   endtask

   task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   // sends nbytes of a frame; B1 = prev parity ^ e when history exists
   task automatic send_frame(input int seed, input logic [7:0] e,
                             input logic [7:0] m1, input int nbytes);
      logic [7:0] par = '0;
      logic [7:0] b;
      for (int p = 0; p < nbytes; p++) begin
         if (p == 0) b = have_prev ? (prev_par ^ e) : e;
         else if (p == M1P) b = m1;
         else b = 8'((seed * 7 + p * 13 + 5) & 255);
         par ^= b;
         @(negedge clk); byte_en = 1'b1; sof = (p == 0); din = b;
         if (p % 3 == 1) begin // R11 idle cycle with garbage data
            @(negedge clk); byte_en = 1'b0; sof = 1'b1; din = 8'hA5;
         end
      end
      @(negedge clk); byte_en = 1'b0; sof = 1'b0; din = '0;
      if (nbytes == NB) begin prev_par = par; have_prev = 1'b1; end
      else have_prev = 1'b0;
   endtask

   initial begin
      repeat (2000000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R12 reset state
      chk("R12 irq_n", int'(irq_n), 1);
      reg_read(2'd0, v); chk("R12 ctrl", v, 0);
      reg_read(2'd1, v); chk("R12 status", v, 0);
      reg_read(2'd2, v); chk("R12 b1 count", v, 0);
      reg_read(2'd3, v); chk("R12 rei count", v, 0);

      // R10 control register
      reg_write(2'd0, 8'hFF);
      reg_read(2'd0, v); chk("R10 ctrl bit7 reads 0", v, 8'h7F);
      reg_write(2'd0, 8'h00);
      reg_read(2'd0, v); chk("R10 ctrl cleared", v, 0);

      // R3 first frame after reset: no compare
      send_frame(1, 8'h5A, 8'd0, NB);
      reg_read(2'd2, v); chk("R3 first frame skipped", v, 0);

      // R1 / R6 / R7 per-bit sweep of every error mask
      for (int e = 0; e < 256; e++) begin
         send_frame(e + 3, 8'(e), 8'd0, NB);
         chk("R6 irq_n after mismatch", int'(irq_n), (e != 0) ? 0 : 1);
         reg_read(2'd2, v); chk("R1 bit count", v, popc(8'(e)));
         reg_read(2'd1, v); chk("R6 status bit3", v, (e != 0) ? 8'h08 : 0);
         chk("R7 irq_n after status read", int'(irq_n), 1);
      end

      // R2 per-frame sweep
      reg_write(2'd0, 8'h01);
      for (int e = 0; e < 256; e++) begin
         send_frame(e * 5 + 1, 8'(e), 8'd0, NB);
         reg_read(2'd2, v); chk("R2 frame count", v, (e != 0) ? 1 : 0);
         reg_read(2'd1, v);
      end

      // R4 remote-error bit mode sweep
      reg_write(2'd0, 8'h00);
      for (int m = 0; m < 256; m++) begin
         send_frame(m + 11, 8'd0, 8'(m), NB);
         reg_read(2'd3, v); chk("R4 rei value count", v, rei_ok(m));
         reg_read(2'd1, v); chk("R6 status bit5", v, (rei_ok(m) != 0) ? 8'h20 : 0);
      end

      // R5 remote-error frame mode sweep
      reg_write(2'd0, 8'h04);
      for (int m = 0; m < 256; m++) begin
         send_frame(m + 17, 8'd0, 8'(m), NB);
         reg_read(2'd3, v); chk("R5 rei frame count", v, (rei_ok(m) != 0) ? 1 : 0);
         reg_read(2'd1, v);
      end

      // R8 saturation of both counters, R9 clear on read
      reg_write(2'd0, 8'h00);
      for (int f = 0; f < 40; f++) send_frame(f + 23, 8'hFF, 8'd24, NB);
      reg_read(2'd2, v); chk("R8 b1 saturates", v, 255);
      reg_read(2'd3, v); chk("R8 rei saturates", v, 255);
      reg_read(2'd2, v); chk("R9 b1 cleared by read", v, 0);
      reg_read(2'd3, v); chk("R9 rei cleared by read", v, 0);
      reg_read(2'd1, v); chk("R6 both status bits", v, 8'h28);
      reg_read(2'd1, v); chk("R7 status cleared", v, 0);

      // R3 loss of frame drops history
      @(negedge clk); lof = 1'b1;
      @(negedge clk); lof = 1'b0;
      have_prev = 1'b0;
      send_frame(31, 8'h33, 8'd0, NB);
      reg_read(2'd2, v); chk("R3 after lof skipped", v, 0);
      send_frame(32, 8'h01, 8'd0, NB);
      reg_read(2'd2, v); chk("R1 compare resumes", v, 1);

      // R3 early frame start drops history
      send_frame(40, 8'h00, 8'd0, 5);
      send_frame(41, 8'h0F, 8'd0, NB);
      reg_read(2'd2, v); chk("R3 after restart skipped", v, 0);
      send_frame(42, 8'h03, 8'd0, NB);
      reg_read(2'd2, v); chk("R1 compare after restart", v, 2);
      reg_read(2'd1, v);
      chk("R7 irq_n idle", int'(irq_n), 1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule